// File: doc/BRIEF.md
# Receive Character Buffer with Trigger Level

This block buffers characters that a serial receiver has already assembled, for a byte-wide register bus to read. Each arriving character carries three error flags (parity, framing, break). In buffered mode, sixteen characters queue in arrival order. A character that arrives while the queue is full waits in a single holding stage. A further arrival while that stage is occupied replaces the waiting character and flags an overrun. In unbuffered mode, one character is held, and a second arrival before the read is dropped with an overrun.

Software configures the block through a control register. That register selects the mode, selects one of four fill thresholds, and carries self-clearing bits that empty the receive queue and request a flush of the transmit side. A status register reports data availability, the overrun, the error flags of the oldest character, a summary error bit, and two transmitter state bits taken from inputs. The threshold comparison drives `trig_hit`, which the interrupt logic uses. The transmit queue itself lives elsewhere: this block only pulses `tx_flush` for it.

Register offsets on `bus_addr`: 0 is the character buffer (read pops), 2 is the control register (write, and readable), 5 is the line status register (read). Read data appears on `bus_rdata` one clock after the read strobe. Read side effects take effect at that same edge.

Top module: `rxq_buffer`

## Requirements
- R1: After reset, `data_ready`, `trig_hit` and `tx_flush` are 0. The control register reads 0x00. With `tx_hold_empty` and `tx_idle` high, line status reads 0x60.
- R2: Control bit 0 selects buffered mode. Bits 7:6 select the threshold: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14 entries. Bits 7:3 and bit 0 read back as written. Bits 1 and 2 always read back as 0.
- R3: In buffered mode, up to sixteen characters are returned by buffer reads in arrival order.
- R4: Line status bit 0 and the `data_ready` port are 1 while at least one character is held, and drop to 0 once the last one is read.
- R5: In buffered mode, `trig_hit` is 1 exactly while the held count is at or above the selected threshold. It falls when a read takes the count below the threshold. In unbuffered mode, `trig_hit` equals `data_ready`.
- R6: In buffered mode, a 17th character waits in the holding stage without an overrun. It enters the queue, behind the earlier characters, as soon as a read frees a slot.
- R7: In buffered mode, an arrival while the queue is full and the holding stage is occupied replaces the held character. It also sets line status bit 1 (overrun) and bit 7 (summary error). With `tx_hold_empty`=1 and `tx_idle`=0, line status then reads 0xA3.
- R8: In unbuffered mode, a second arrival before the held character is read sets bit 1 but not bit 7. The first character is kept and the new one is dropped.
- R9: Reading line status clears bits 1 and 7 after returning them. An overrun in the same cycle as that read leaves bit 1 set.
- R10: Writing control bit 1 empties the queue and the holding stage. Writing bit 2 drives `tx_flush` high for exactly one cycle. Neither bit changes the stored control fields. A flush takes priority over an arrival in the same cycle.
- R11: A control write that changes bit 0 empties the receive queue and pulses `tx_flush`.
- R12: Line status bits 2, 3 and 4 show the parity, framing and break flags of the oldest held character. In buffered mode, queueing a character that has any flag set also sets bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error flag of the character |
| rx_ferr | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Break flag of the character |
| tx_hold_empty | input | 1 | Transmit holding storage is empty (status bit 5) |
| tx_idle | input | 1 | Transmitter fully idle (status bit 6) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| data_ready | output | 1 | At least one character held |
| trig_hit | output | 1 | Fill threshold reached |
| tx_flush | output | 1 | One-cycle request to empty the transmit queue |
| fifo_on | output | 1 | Buffered mode active |

## Verification
The overrun event and a line status read can fall in the same cycle. The clear-on-read then competes with the set from the arrival. The bench provokes this by raising `rx_valid` in the same clock as a status read while the holding register is already full. It judges the result from two successive status reads: the first must still show the old bit 1 as clear, and the second must show it set. A second collision is a buffer read at the same edge as the holding stage's hand-over into the freed slot. That one is judged by the order of the returned characters.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Register offsets on the byte-wide bus.
  localparam logic [2:0] ADDR_RXBUF = 3'd0;
  localparam logic [2:0] ADDR_FCTL  = 3'd2;
  localparam logic [2:0] ADDR_LSTAT = 3'd5;

  // One buffered character with its receive flags.
  // The flag order matches status bits 4..2.
  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rxq_ent_t;

  // Threshold selected by the two control bits, scaled from the depth.
  function automatic int unsigned trig_level(input logic [1:0] sel,
                                             input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [7:0]    wdata,
  output logic          fifo_on,
  output logic [7:0]    fctl_rd,
  output logic          rx_clr,
  output logic          tx_flush,
  output logic [CW-1:0] trig_lvl
);

  logic       en_q;
  logic [1:0] sel_q;
  logic [2:0] spare_q;
  logic       mode_chg;

  assign mode_chg = wr && (wdata[0] != en_q);
  assign rx_clr   = wr && (wdata[1] || mode_chg);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      sel_q    <= 2'd0;
      spare_q  <= 3'd0;
      tx_flush <= 1'b0;
    end else begin
      tx_flush <= wr && (wdata[2] || mode_chg);
      if (wr) begin
        en_q    <= wdata[0];
        sel_q   <= wdata[7:6];
        spare_q <= wdata[5:3];
      end
    end
  end

  assign fifo_on  = en_q;
  assign fctl_rd  = {sel_q, spare_q, 2'b00, en_q};
  assign trig_lvl = en_q ? CW'(trig_level(sel_q, DEPTH)) : CW'(1);

  // R5: the threshold always lies inside the queue range
  a_r5_trig_range: assert property (@(posedge clk) disable iff (rst)
    (trig_lvl >= CW'(1)) && (trig_lvl <= CW'(DEPTH)));

  // R10: a flush request follows a write that asked for it
  a_r10_flush_cause: assert property (@(posedge clk) disable iff (rst)
    tx_flush |-> $past(wr));

endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  rxq_ent_t      push_ent,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic [2:0]    head_flags,
  output logic [7:0]    rd_data
);

  logic [7:0]    mem_d [DEPTH];
  logic [2:0]    mem_f [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // Storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push) begin
      mem_d[wr_ptr] <= push_ent.data;
      mem_f[wr_ptr] <= {push_ent.brk, push_ent.ferr, push_ent.perr};
    end
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= 8'h00;
    else if (pop && !clr)
      rd_data <= mem_d[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign head_flags = (count != '0) ? mem_f[rd_ptr] : 3'b000;

  // R3: a push without a pop never exceeds the queue depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !clr) |-> (count < CW'(DEPTH)));

  // R4: a lone push raises the count by one
  a_r4_fill_step: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !clr) |=> (count == $past(count) + CW'(1)));

  // R10: a flush leaves the queue empty
  a_r10_clr_empty: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

endmodule

// File: rtl/rxq_ingress.sv
module rxq_ingress
  import rxq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  logic     fifo_on,
  input  logic     rx_valid,
  input  rxq_ent_t rx_ent,
  input  logic     room,
  input  logic     pop,
  output logic     push,
  output rxq_ent_t push_ent,
  output logic     overrun_ev
);

  logic     sreg_v;
  rxq_ent_t sreg_q;
  logic     can;

  // A slot is free now, or one frees at this edge.
  assign can        = room || pop;
  assign push       = !clr && can && (sreg_v || rx_valid);
  assign push_ent   = sreg_v ? sreg_q : rx_ent;
  assign overrun_ev = !clr && rx_valid && !can && (sreg_v || !fifo_on);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sreg_v <= 1'b0;
      sreg_q <= '0;
    end else if (sreg_v) begin
      if (can) begin
        sreg_v <= rx_valid;
        if (rx_valid) sreg_q <= rx_ent;
      end else if (rx_valid) begin
        sreg_q <= rx_ent;
      end
    end else if (rx_valid && !can && fifo_on) begin
      sreg_v <= 1'b1;
      sreg_q <= rx_ent;
    end
  end

  // R6: the holding stage is occupied only while the queue is full
  a_r6_stage_when_full: assert property (@(posedge clk) disable iff (rst)
    sreg_v |-> !room);

  // R6: a waiting character moves on as soon as a slot opens
  a_r6_stage_drains: assert property (@(posedge clk) disable iff (rst)
    (sreg_v && pop && !clr) |-> push);

  // R8: in unbuffered mode an overrun never stores the new character
  a_r8_drop_new: assert property (@(posedge clk) disable iff (rst)
    (overrun_ev && !fifo_on) |=> !sreg_v);

endmodule

// File: rtl/rxq_lsr.sv
module rxq_lsr (
  input  logic       clk,
  input  logic       rst,
  input  logic       fifo_on,
  input  logic       overrun_ev,
  input  logic       err_push,
  input  logic       lsr_rd,
  input  logic       has_data,
  input  logic [2:0] head_flags,
  input  logic       tx_hold_empty,
  input  logic       tx_idle,
  output logic [7:0] lsr_val
);

  logic oe_q;
  logic sum_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      sum_q <= 1'b0;
    end else begin
      if (overrun_ev)  oe_q <= 1'b1;
      else if (lsr_rd) oe_q <= 1'b0;
      if ((overrun_ev && fifo_on) || err_push) sum_q <= 1'b1;
      else if (lsr_rd)                         sum_q <= 1'b0;
    end
  end

  assign lsr_val = {sum_q, tx_idle, tx_hold_empty, head_flags, oe_q, has_data};

  // R9: a status read without a new overrun clears bit 1
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !overrun_ev) |=> !lsr_val[1]);

  // R9: an overrun is recorded even when a read hits the same cycle
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    overrun_ev |=> lsr_val[1]);

  // R7: an overrun in buffered mode raises the summary bit
  a_r7_summary: assert property (@(posedge clk) disable iff (rst)
    (overrun_ev && fifo_on) |=> lsr_val[7]);

endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_brk,
  input  logic       tx_hold_empty,
  input  logic       tx_idle,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       data_ready,
  output logic       trig_hit,
  output logic       tx_flush,
  output logic       fifo_on
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          fctl_wr, lsr_rd, pop, rx_clr, room;
  logic          push, overrun_ev, err_push;
  logic [7:0]    fctl_rd, lsr_val, buf_data, lsr_q;
  logic [2:0]    head_flags, addr_q;
  logic [CW-1:0] count, trig_lvl, cap;
  rxq_ent_t      rx_ent, push_ent;

  assign fctl_wr = bus_wr && (bus_addr == ADDR_FCTL);
  assign lsr_rd  = bus_rd && (bus_addr == ADDR_LSTAT);
  assign pop     = bus_rd && (bus_addr == ADDR_RXBUF) && (count != '0);

  assign rx_ent  = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};
  assign cap     = fifo_on ? CW'(DEPTH) : CW'(1);
  assign room    = count < cap;

  rxq_ctrl #(.DEPTH(DEPTH), .CW(CW)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr       (fctl_wr),
    .wdata    (bus_wdata),
    .fifo_on  (fifo_on),
    .fctl_rd  (fctl_rd),
    .rx_clr   (rx_clr),
    .tx_flush (tx_flush),
    .trig_lvl (trig_lvl)
  );

  rxq_ingress i_ingress (
    .clk        (clk),
    .rst        (rst),
    .clr        (rx_clr),
    .fifo_on    (fifo_on),
    .rx_valid   (rx_valid),
    .rx_ent     (rx_ent),
    .room       (room),
    .pop        (pop),
    .push       (push),
    .push_ent   (push_ent),
    .overrun_ev (overrun_ev)
  );

  rxq_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) i_store (
    .clk        (clk),
    .rst        (rst),
    .clr        (rx_clr),
    .push       (push),
    .push_ent   (push_ent),
    .pop        (pop),
    .count      (count),
    .head_flags (head_flags),
    .rd_data    (buf_data)
  );

  assign err_push = push && fifo_on && (push_ent.perr || push_ent.ferr || push_ent.brk);

  rxq_lsr i_lsr (
    .clk           (clk),
    .rst           (rst),
    .fifo_on       (fifo_on),
    .overrun_ev    (overrun_ev),
    .err_push      (err_push),
    .lsr_rd        (lsr_rd),
    .has_data      (count != '0),
    .head_flags    (head_flags),
    .tx_hold_empty (tx_hold_empty),
    .tx_idle       (tx_idle),
    .lsr_val       (lsr_val)
  );

  // Read path: the offset and the status snapshot are taken at the read edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= 3'd0;
      lsr_q  <= 8'h00;
    end else if (bus_rd) begin
      addr_q <= bus_addr;
      if (lsr_rd) lsr_q <= lsr_val;
    end
  end

  always_comb begin
    case (addr_q)
      ADDR_RXBUF: bus_rdata = buf_data;
      ADDR_FCTL:  bus_rdata = fctl_rd;
      ADDR_LSTAT: bus_rdata = lsr_q;
      default:    bus_rdata = 8'h00;
    endcase
  end

  assign data_ready = (count != '0);
  assign trig_hit   = (count >= trig_lvl);

  // R4: emptying by a read clears data-ready on the next cycle
  a_r4_last_read: assert property (@(posedge clk) disable iff (rst)
    (pop && (count == CW'(1)) && !push) |=> !data_ready);

  // R8: unbuffered mode never holds more than one character
  a_r8_single_hold: assert property (@(posedge clk) disable iff (rst)
    !fifo_on |-> (count <= CW'(1)));

  // R11: a mode change leaves the receive side empty
  a_r11_mode_flush: assert property (@(posedge clk) disable iff (rst)
    (fifo_on != $past(fifo_on)) |-> !data_ready);

endmodule

// File: tb/test_rxq_buffer.sv
module test_rxq_buffer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic       tx_hold_empty = 1'b1, tx_idle = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       data_ready, trig_hit, tx_flush, fifo_on;

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] A_BUF = 3'd0;
  localparam logic [2:0] A_CTL = 3'd2;
  localparam logic [2:0] A_LSR = 3'd5;

  // {control value, characters pushed, expected trig_hit}
  localparam logic [16:0] TV [8] = '{
    {8'h01, 8'd0,  1'b0}, {8'h01, 8'd1,  1'b1},
    {8'h41, 8'd3,  1'b0}, {8'h41, 8'd4,  1'b1},
    {8'h81, 8'd7,  1'b0}, {8'h81, 8'd8,  1'b1},
    {8'hC1, 8'd13, 1'b0}, {8'hC1, 8'd14, 1'b1}
  };

  always #5 clk = ~clk;

  rxq_buffer #(.DEPTH(16)) i_rxq_buffer (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .tx_hold_empty(tx_hold_empty), .tx_idle(tx_idle),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .data_ready(data_ready), .trig_hit(trig_hit),
    .tx_flush(tx_flush), .fifo_on(fifo_on)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic pe = 0,
                      input logic fe = 0, input logic bk = 0);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_perr = pe; rx_ferr = fe; rx_brk = bk;
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 data_ready", {7'd0, data_ready}, 8'h00);
    chk("R1 trig_hit", {7'd0, trig_hit}, 8'h00);
    chk("R1 tx_flush", {7'd0, tx_flush}, 8'h00);
    rd(A_LSR, v); chk("R1 status", v, 8'h60);
    rd(A_CTL, v); chk("R1 control", v, 8'h00);

    // R5 threshold table walk (each entry starts from an emptied queue)
    for (int i = 0; i < 8; i++) begin
      wr(A_CTL, TV[i][16:9] | 8'h02);
      for (int j = 0; j < int'(TV[i][8:1]); j++) push(8'(j));
      chk($sformatf("R5 trig vec %0d", i), {7'd0, trig_hit}, {7'd0, TV[i][0]});
      chk($sformatf("R4 ready vec %0d", i), {7'd0, data_ready},
          {7'd0, (TV[i][8:1] != 8'd0)});
    end
    // R5 falls below threshold 14 after one read; R3 oldest first
    rd(A_BUF, v); chk("R3 first out", v, 8'h00);
    chk("R5 trig falls", {7'd0, trig_hit}, 8'h00);
    // R2 readback with self-clearing bits
    wr(A_CTL, 8'hC7);
    rd(A_CTL, v); chk("R2 readback", v, 8'hC1);

    // R6 / R7 / R3: fill, wait in stage, overrun
    tx_idle = 1'b0;
    wr(A_CTL, 8'h03);
    for (int j = 0; j < 17; j++) push(8'(j));
    rd(A_LSR, v); chk("R6 seventeen no overrun", v, 8'h21);
    push(8'd17);
    rd(A_LSR, v); chk("R7 overrun status", v, 8'hA3);
    rd(A_LSR, v); chk("R9 cleared by read", v, 8'h21);
    for (int j = 0; j < 16; j++) begin
      rd(A_BUF, v); chk($sformatf("R3 order %0d", j), v, 8'(j));
    end
    rd(A_BUF, v); chk("R6 stage moved in", v, 8'd17);
    rd(A_LSR, v); chk("R4 empty after last", v, 8'h20);
    tx_idle = 1'b1;

    // R10 flush bits
    for (int j = 0; j < 3; j++) push(8'h40 + 8'(j));
    wr(A_CTL, 8'h07);
    chk("R10 tx_flush pulse", {7'd0, tx_flush}, 8'h01);
    chk("R10 rx emptied", {7'd0, data_ready}, 8'h00);
    @(negedge clk);
    chk("R10 pulse ends", {7'd0, tx_flush}, 8'h00);
    rd(A_CTL, v); chk("R10 fields kept", v, 8'h01);
    push(8'h77);
    rd(A_BUF, v); chk("R10 queue usable", v, 8'h77);

    // R11 mode change flushes
    push(8'h12);
    wr(A_CTL, 8'h00);
    chk("R11 tx_flush", {7'd0, tx_flush}, 8'h01);
    chk("R11 rx emptied", {7'd0, data_ready}, 8'h00);

    // R8 unbuffered overrun
    push(8'h11);
    chk("R5 unbuffered trig", {7'd0, trig_hit}, 8'h01);
    push(8'h22);
    rd(A_LSR, v); chk("R8 overrun no bit7", v, 8'h63);
    rd(A_BUF, v); chk("R8 older kept", v, 8'h11);
    rd(A_LSR, v); chk("R9 bits cleared", v, 8'h60);

    // R9 overrun in the same cycle as a status read
    push(8'h33);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = A_LSR; rx_valid = 1'b1; rx_data = 8'h44;
    @(negedge clk);
    bus_rd = 1'b0; rx_valid = 1'b0;
    chk("R9 snapshot before set", bus_rdata, 8'h61);
    rd(A_LSR, v); chk("R9 set wins", v, 8'h63);
    rd(A_LSR, v); chk("R9 then cleared", v, 8'h61);
    rd(A_BUF, v); chk("R8 held value", v, 8'h33);

    // R12 error flags
    push(8'h55, 1'b0, 1'b0, 1'b1);
    rd(A_LSR, v); chk("R12 break unbuffered", v, 8'h71);
    rd(A_BUF, v); chk("R12 data", v, 8'h55);
    wr(A_CTL, 8'h01);
    push(8'h66, 1'b1, 1'b0, 1'b0);
    rd(A_LSR, v); chk("R12 parity summary", v, 8'hE5);
    rd(A_LSR, v); chk("R12 summary cleared", v, 8'h65);
    rd(A_BUF, v); chk("R12 data buffered", v, 8'h66);
    rd(A_LSR, v); chk("R12 flags follow head", v, 8'h60);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule